// File: doc/BRIEF.md
# Translation Cache Flush Controller

This block sits in front of a set of translation caches: one private micro TLB for each of several bus masters, one shared macro TLB and a cache of page-table-walk results. Software starts a flush by writing a one to the bit of each cache it wants emptied. The controller sends each chosen cache a single-cycle invalidate pulse. It keeps that cache's bit set until the cache acknowledges. Each bit clears on its own, so software polls the register and treats a zero readback as the end of the whole flush.

A second path invalidates only part of the caches. Software loads an address value and a mask value, then sets the trigger bit of an enable register. The controller presents the masked address and the mask to the caches with one pulse. A cache drops every entry whose tag, ANDed with the mask, equals that masked address. The trigger bit stays set until the acknowledge arrives. The caches are outside this block and are seen only through their invalidate and acknowledge wires.

Top module: `tlbf_top`

## Requirements
- R1: Register select 0 is the flush register. Bit i (i = 0..5) targets micro TLB i, bit 16 the macro TLB and bit 17 the walk cache. Writing 1 to a bit raises that target's invalidate output in the cycle after the write cycle, and the bit reads back as 1 from that cycle on.
- R2: An invalidate pulse lasts one cycle. It repeats in the next cycle only through the re-arm case of R8.
- R3: Each pending bit clears independently. It reads 0 in the cycle after the cycle in which its target's acknowledge is high. The register reads all zero once every requested target has acknowledged.
- R4: Written values in flush register bits other than 5:0, 16 and 17 are ignored, and those bits always read 0.
- R5: A write during an ongoing flush ORs the new bits into the pending set. Only the newly set bits produce pulses.
- R6: Writing 1 to a bit that is already pending produces no new pulse, and the bit stays pending.
- R7: An acknowledge from a target that has no pending bit has no effect.
- R8: If a target's acknowledge and a write of 1 to its bit occur in the same cycle, the bit stays pending and a fresh pulse is issued in the next cycle.
- R9: Register select 3 is the range-enable register, and its bit 0 is the trigger. Writing 1 to the trigger while idle raises rangeInv for one cycle in the next cycle. During that pulse rangeAddr equals the address register AND the mask register, and rangeMask equals the mask register. The trigger reads 1 until the cycle after rangeAck is high. An acknowledge in the pulse cycle is accepted.
- R10: While a range invalidate is in progress, writes to the address, mask and enable registers are ignored, and rangeAddr and rangeMask hold steady.
- R11: Register select 1 (address) and select 2 (mask) read back the raw written value. Writing 0 to the trigger bit starts nothing.
- R12: After reset every register reads 0 and no invalidate output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select: 0 flush, 1 address, 2 mask, 3 range enable |
| cfgWrData | input | DATA_W | Write data |
| cfgRdData | output | DATA_W | Read data of the selected register |
| microInv | output | NUM_MASTERS | Invalidate pulses to the micro TLBs |
| microAck | input | NUM_MASTERS | Acknowledges from the micro TLBs |
| macroInv | output | 1 | Invalidate pulse to the macro TLB |
| macroAck | input | 1 | Acknowledge from the macro TLB |
| walkInv | output | 1 | Invalidate pulse to the walk cache |
| walkAck | input | 1 | Acknowledge from the walk cache |
| rangeInv | output | 1 | Range invalidate pulse |
| rangeAddr | output | DATA_W | Masked address for the range invalidate |
| rangeMask | output | DATA_W | Mask for the range invalidate |
| rangeAck | input | 1 | Range invalidate acknowledge |

## Verification
The hardest case to reach is a target whose acknowledge arrives in the same cycle as a software write to that target's bit. Ports alone rarely produce it, because the pulse, the acknowledge and the write must line up exactly. The stimulus starts a walk-cache flush, then in one cycle drives walkAck high and writes bit 17 again. It then checks that the bit stays set and that a second pulse follows. The range path gets the same treatment: its acknowledge is driven during the pulse cycle itself, and new address values are written while the invalidate is in progress.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;
  typedef enum logic [1:0] {
    SEL_FLUSH = 2'd0,
    SEL_RADDR = 2'd1,
    SEL_RMASK = 2'd2,
    SEL_REN   = 2'd3
  } tlbf_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic flushWr;
    logic addrWr;
    logic maskWr;
    logic rangeStart;
    logic rangeDone;
  } tlbf_strobe_t;

  typedef enum logic [1:0] {
    RG_IDLE  = 2'd0,
    RG_ISSUE = 2'd1,
    RG_WAIT  = 2'd2
  } tlbf_range_e;
endpackage

// File: rtl/tlbf_ctrl.sv
module tlbf_ctrl
  import tlbf_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic [1:0]   cfgSel,
  input  logic         trigBit,
  input  logic         rangeAck,
  output tlbf_strobe_t strobe,
  output logic         rangeInv,
  output logic         rangeBusyCtl
);
  tlbf_range_e state, stateNext;
  logic        idle;

  assign idle = (state == RG_IDLE);

  always_comb begin
    strobe            = '0;
    strobe.flushWr    = cfgWrEn && (cfgSel == SEL_FLUSH);
    strobe.addrWr     = cfgWrEn && (cfgSel == SEL_RADDR) && idle;
    strobe.maskWr     = cfgWrEn && (cfgSel == SEL_RMASK) && idle;
    strobe.rangeStart = cfgWrEn && (cfgSel == SEL_REN) && trigBit && idle;
    strobe.rangeDone  = !idle && rangeAck;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      RG_IDLE:  if (strobe.rangeStart) stateNext = RG_ISSUE;
      RG_ISSUE: stateNext = rangeAck ? RG_IDLE : RG_WAIT;
      RG_WAIT:  if (rangeAck) stateNext = RG_IDLE;
      default:  stateNext = RG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= RG_IDLE;
    else       state <= stateNext;
  end

  assign rangeInv     = (state == RG_ISSUE);
  assign rangeBusyCtl = !idle;
endmodule

// File: rtl/tlbf_dpath.sv
module tlbf_dpath
  import tlbf_pkg::*;
#(
  parameter int NUM_MASTERS = 6,
  parameter int MACRO_BIT   = 16,
  parameter int WALK_BIT    = 17,
  parameter int DATA_W      = 32,
  localparam int NT         = NUM_MASTERS + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbf_strobe_t       strobe,
  input  logic [1:0]         cfgSel,
  input  logic [DATA_W-1:0]  cfgWrData,
  input  logic [NT-1:0]      ackVec,
  output logic [NT-1:0]      invVec,
  output logic [NT-1:0]      pendVec,
  output logic               enBit,
  output logic [DATA_W-1:0]  cfgRdData,
  output logic [DATA_W-1:0]  rangeAddr,
  output logic [DATA_W-1:0]  rangeMask
);
  logic [NT-1:0]     wrTgt;
  logic [NT-1:0]     setTgt;
  logic [DATA_W-1:0] flushRd;
  logic [DATA_W-1:0] addrReg, maskReg;

  // map register bit positions onto the target vector
  always_comb begin
    wrTgt = '0;
    for (int i = 0; i < NUM_MASTERS; i++) wrTgt[i] = cfgWrData[i];
    wrTgt[NUM_MASTERS]     = cfgWrData[MACRO_BIT];
    wrTgt[NUM_MASTERS + 1] = cfgWrData[WALK_BIT];
  end

  assign setTgt = wrTgt & {NT{strobe.flushWr}};

  for (genvar t = 0; t < NT; t++) begin : g_tgt
    logic pendQ, invQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendQ <= 1'b0;
        invQ  <= 1'b0;
      end else if (setTgt[t] && (!pendQ || ackVec[t])) begin
        pendQ <= 1'b1;
        invQ  <= 1'b1;
      end else begin
        invQ <= 1'b0;
        if (ackVec[t]) pendQ <= 1'b0;
      end
    end
    assign pendVec[t] = pendQ;
    assign invVec[t]  = invQ;
  end

  always_comb begin
    flushRd = '0;
    for (int i = 0; i < NUM_MASTERS; i++) flushRd[i] = pendVec[i];
    flushRd[MACRO_BIT] = pendVec[NUM_MASTERS];
    flushRd[WALK_BIT]  = pendVec[NUM_MASTERS + 1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      maskReg <= '0;
      enBit   <= 1'b0;
    end else begin
      if (strobe.addrWr)     addrReg <= cfgWrData;
      if (strobe.maskWr)     maskReg <= cfgWrData;
      if (strobe.rangeStart) enBit   <= 1'b1;
      else if (strobe.rangeDone) enBit <= 1'b0;
    end
  end

  assign rangeAddr = addrReg & maskReg;
  assign rangeMask = maskReg;

  always_comb begin
    unique case (tlbf_sel_e'(cfgSel))
      SEL_FLUSH: cfgRdData = flushRd;
      SEL_RADDR: cfgRdData = addrReg;
      SEL_RMASK: cfgRdData = maskReg;
      default:   cfgRdData = {{(DATA_W-1){1'b0}}, enBit};
    endcase
  end
endmodule

// File: rtl/tlbf_top.sv
module tlbf_top
  import tlbf_pkg::*;
#(
  parameter int NUM_MASTERS = 6,
  parameter int MACRO_BIT   = 16,
  parameter int WALK_BIT    = 17,
  parameter int DATA_W      = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic [1:0]             cfgSel,
  input  logic [DATA_W-1:0]      cfgWrData,
  output logic [DATA_W-1:0]      cfgRdData,
  output logic [NUM_MASTERS-1:0] microInv,
  input  logic [NUM_MASTERS-1:0] microAck,
  output logic                   macroInv,
  input  logic                   macroAck,
  output logic                   walkInv,
  input  logic                   walkAck,
  output logic                   rangeInv,
  output logic [DATA_W-1:0]      rangeAddr,
  output logic [DATA_W-1:0]      rangeMask,
  input  logic                   rangeAck
);
  localparam int NT = NUM_MASTERS + 2;

  tlbf_strobe_t  strobe;
  logic [NT-1:0] ackVec, invVec, pendVec;
  logic          enBit, rangeBusyCtl;

  assign ackVec = {walkAck, macroAck, microAck};

  tlbf_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .trigBit(cfgWrData[0]), .rangeAck(rangeAck), .strobe(strobe),
    .rangeInv(rangeInv), .rangeBusyCtl(rangeBusyCtl)
  );

  tlbf_dpath #(
    .NUM_MASTERS(NUM_MASTERS), .MACRO_BIT(MACRO_BIT),
    .WALK_BIT(WALK_BIT), .DATA_W(DATA_W)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .ackVec(ackVec), .invVec(invVec),
    .pendVec(pendVec), .enBit(enBit), .cfgRdData(cfgRdData),
    .rangeAddr(rangeAddr), .rangeMask(rangeMask)
  );

  assign microInv = invVec[NUM_MASTERS-1:0];
  assign macroInv = invVec[NUM_MASTERS];
  assign walkInv  = invVec[NUM_MASTERS+1];
endmodule

// File: rtl/tlbf_checker.sv
module tlbf_checker #(
  parameter int NUM_MASTERS = 6,
  parameter int MACRO_BIT   = 16,
  parameter int WALK_BIT    = 17,
  parameter int DATA_W      = 32,
  localparam int NT         = NUM_MASTERS + 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   cfgWrEn,
  input logic [1:0]             cfgSel,
  input logic [DATA_W-1:0]      cfgRdData,
  input logic [NUM_MASTERS-1:0] microInv,
  input logic [NUM_MASTERS-1:0] microAck,
  input logic                   macroInv,
  input logic                   macroAck,
  input logic                   walkInv,
  input logic                   walkAck,
  input logic                   rangeInv,
  input logic [DATA_W-1:0]      rangeAddr,
  input logic [DATA_W-1:0]      rangeMask,
  input logic [NT-1:0]          pendVec,
  input logic                   enBit,
  input logic                   rangeBusyCtl
);
  logic [NT-1:0]     tgtInv, tgtAck;
  logic [DATA_W-1:0] validBits;

  assign tgtInv = {walkInv, macroInv, microInv};
  assign tgtAck = {walkAck, macroAck, microAck};

  always_comb begin
    validBits = '0;
    for (int i = 0; i < NUM_MASTERS; i++) validBits[i] = 1'b1;
    validBits[MACRO_BIT] = 1'b1;
    validBits[WALK_BIT]  = 1'b1;
  end

  // R1: a pulse only goes to a target that is pending
  a_r1_pulse_pending: assert property (@(posedge clk) disable iff (!rstN)
    (tgtInv & ~pendVec) == '0);

  // R2: without an acknowledge a pulse never lasts a second cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (tgtInv & $past(tgtInv & ~tgtAck)) == '0);

  // R3: an acknowledged pending bit is gone when no write interferes
  a_r3_clear_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    $past(!cfgWrEn) |-> ((pendVec & $past(pendVec & tgtAck)) == '0));

  // R5: a pending bit never drops without its acknowledge
  a_r5_no_lost_bit: assert property (@(posedge clk) disable iff (!rstN)
    (~pendVec & $past(pendVec & ~tgtAck)) == '0);

  // R4: unused flush bits read zero
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSel == 2'd0) |-> ((cfgRdData & ~validBits) == '0));

  // R9: trigger bit agrees with the range sequencer
  a_r9_busy_agree: assert property (@(posedge clk) disable iff (!rstN)
    enBit == rangeBusyCtl);

  // R9: range pulse lasts one cycle
  a_r9_range_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rangeInv |=> !rangeInv);

  // R10: range outputs hold while the invalidate runs
  a_r10_range_stable: assert property (@(posedge clk) disable iff (!rstN)
    (rangeBusyCtl && $past(rangeBusyCtl)) |-> ($stable(rangeAddr) && $stable(rangeMask)));
endmodule

bind tlbf_top tlbf_checker #(
  .NUM_MASTERS(NUM_MASTERS), .MACRO_BIT(MACRO_BIT),
  .WALK_BIT(WALK_BIT), .DATA_W(DATA_W)
) i_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
  .cfgRdData(cfgRdData), .microInv(microInv), .microAck(microAck),
  .macroInv(macroInv), .macroAck(macroAck), .walkInv(walkInv),
  .walkAck(walkAck), .rangeInv(rangeInv), .rangeAddr(rangeAddr),
  .rangeMask(rangeMask), .pendVec(pendVec), .enBit(enBit),
  .rangeBusyCtl(rangeBusyCtl)
);

// File: tb/test_tlbf_top.sv
module test_tlbf_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic [5:0]  microInv;
  logic [5:0]  microAck = '0;
  logic        macroInv, walkInv, rangeInv;
  logic        macroAck = 1'b0, walkAck = 1'b0, rangeAck = 1'b0;
  logic [31:0] rangeAddr, rangeMask;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  tlbf_top i_tlbf_top (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .microInv(microInv),
    .microAck(microAck), .macroInv(macroInv), .macroAck(macroAck),
    .walkInv(walkInv), .walkAck(walkAck), .rangeInv(rangeInv),
    .rangeAddr(rangeAddr), .rangeMask(rangeMask), .rangeAck(rangeAck)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrData = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] val);
    cfgSel = sel;
    #1;
    val = cfgRdData;
  endtask

  task automatic ack(input logic [5:0] mi, input logic ma, input logic wk);
    microAck = mi; macroAck = ma; walkAck = wk;
    @(negedge clk);
    microAck = '0; macroAck = 1'b0; walkAck = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk("R12 register zero", v, 0);
    end
    chk("R12 no pulses", {microInv, macroInv, walkInv, rangeInv}, 0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    wr(2'd0, 32'h8);
    chk("R1 micro3 pulse", {26'd0, microInv}, 32'h8);
    chk("R1 macro/walk quiet", {macroInv, walkInv}, 0);
    rd(2'd0, v); chk("R1 pending readback", v, 32'h8);
    cyc();
    chk("R2 pulse ended", {26'd0, microInv}, 0);
    rd(2'd0, v); chk("R2 still pending", v, 32'h8);
    ack(6'h08, 1'b0, 1'b0);
    rd(2'd0, v); chk("R3 cleared after ack", v, 0);
  endtask

  task automatic t_all();
    logic [31:0] v;
    wr(2'd0, 32'h0003_003F);
    chk("R1 all micro pulses", {26'd0, microInv}, 32'h3F);
    chk("R1 macro and walk pulses", {macroInv, walkInv}, 2'b11);
    cyc();
    ack(6'h04, 1'b0, 1'b0);
    rd(2'd0, v); chk("R3 micro2 only", v, 32'h0003_003B);
    ack(6'h00, 1'b1, 1'b0);
    rd(2'd0, v); chk("R3 macro cleared", v, 32'h0002_003B);
    ack(6'h3B, 1'b0, 1'b1);
    rd(2'd0, v); chk("R3 all done reads zero", v, 0);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(2'd0, 32'hFFFC_FFC0);
    rd(2'd0, v); chk("R4 reserved ignored", v, 0);
    chk("R4 no pulse", {microInv, macroInv, walkInv}, 0);
  endtask

  task automatic t_merge();
    logic [31:0] v;
    wr(2'd0, 32'h1);
    cyc();
    wr(2'd0, 32'h2);
    chk("R5 only new bit pulses", {26'd0, microInv}, 32'h2);
    rd(2'd0, v); chk("R5 ORed set", v, 32'h3);
    cyc();
    wr(2'd0, 32'h1);
    chk("R6 no repulse", {26'd0, microInv}, 0);
    rd(2'd0, v); chk("R6 stays pending", v, 32'h3);
    ack(6'h03, 1'b0, 1'b0);
    rd(2'd0, v); chk("R3 merged cleared", v, 0);
  endtask

  task automatic t_stray();
    logic [31:0] v;
    ack(6'h00, 1'b1, 1'b0);
    rd(2'd0, v); chk("R7 stray ack idle", v, 0);
    chk("R7 no pulse", {31'd0, macroInv}, 0);
    wr(2'd0, 32'h0001_0000);
    cyc();
    ack(6'h00, 1'b0, 1'b1);
    rd(2'd0, v); chk("R7 walk ack ignored", v, 32'h0001_0000);
    ack(6'h00, 1'b1, 1'b0);
    rd(2'd0, v); chk("R3 macro done", v, 0);
  endtask

  task automatic t_rearm();
    logic [31:0] v;
    wr(2'd0, 32'h0002_0000);
    cyc();
    walkAck = 1'b1;
    wr(2'd0, 32'h0002_0000);
    walkAck = 1'b0;
    chk("R8 new pulse", {31'd0, walkInv}, 1);
    rd(2'd0, v); chk("R8 stays pending", v, 32'h0002_0000);
    cyc();
    chk("R2 rearm pulse ended", {31'd0, walkInv}, 0);
    ack(6'h00, 1'b0, 1'b1);
    rd(2'd0, v); chk("R3 walk done", v, 0);
  endtask

  task automatic t_range();
    logic [31:0] v;
    wr(2'd1, 32'h1234_5678);
    wr(2'd2, 32'hFFFF_F000);
    rd(2'd1, v); chk("R11 addr readback", v, 32'h1234_5678);
    rd(2'd2, v); chk("R11 mask readback", v, 32'hFFFF_F000);
    wr(2'd3, 32'h0);
    chk("R11 zero trigger idle", {31'd0, rangeInv}, 0);
    rd(2'd3, v); chk("R11 enable stays 0", v, 0);
    wr(2'd3, 32'h1);
    chk("R9 range pulse", {31'd0, rangeInv}, 1);
    chk("R9 masked addr", rangeAddr, 32'h1234_5000);
    chk("R9 mask out", rangeMask, 32'hFFFF_F000);
    rd(2'd3, v); chk("R9 enable busy", v, 1);
    cyc();
    chk("R9 pulse ended", {31'd0, rangeInv}, 0);
    wr(2'd1, 32'hAAAA_AAAA);
    wr(2'd2, 32'h0000_FFFF);
    wr(2'd3, 32'h1);
    chk("R10 no new pulse", {31'd0, rangeInv}, 0);
    rd(2'd1, v); chk("R10 addr write ignored", v, 32'h1234_5678);
    chk("R10 range outputs held", rangeAddr, 32'h1234_5000);
    rangeAck = 1'b1; cyc(); rangeAck = 1'b0;
    rd(2'd3, v); chk("R9 enable cleared", v, 0);
    // acknowledge inside the pulse cycle
    wr(2'd3, 32'h1);
    rangeAck = 1'b1; cyc(); rangeAck = 1'b0;
    rd(2'd3, v); chk("R9 early ack accepted", v, 0);
    chk("R9 no further pulse", {31'd0, rangeInv}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc();
    t_reset();
    t_single();
    t_all();
    t_reserved();
    t_merge();
    t_stray();
    t_rearm();
    t_range();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule